// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block decides when a clock generator's outputs run, when they are parked, and when the oscillator and PLL may be switched off. All of this is controlled from one shared input pin. After reset the pin is read as a power-good indication. Its low level has no effect until it has been seen high once. From then on the same pin is an active-low power-down request. It is brought into the clock domain through a two-stage synchronizer, and it must be seen low on two consecutive cycles before it is accepted.

On an accepted request, each single-ended lane stops at the next high-to-low transition of its clock, so no shortened high pulse is produced. Each differential lane stops at the next falling edge of its complement leg. The lane's own drive-mode bit then picks the parked level: either true leg driven high with complement tri-stated, or both legs tri-stated. A lane that shows no such edge within a fixed window is parked by force. Only when every lane is parked does the PLL/oscillator enable drop. When the pin returns high the enable is raised again. The block waits for PLL lock, or for a timeout if lock never comes. It then drives every differential lane to the parked-high level for a short wake phase, and finally releases all lanes in one cycle.

The clock lanes are modelled as sampled waveforms. Each output is a registered copy of its input lane, gated by the sequencer.

Top module: `pwrdn_seq`

## Requirements
- R1: While reset is asserted, the enable output is 0, every single-ended output is 0, and every differential leg is tri-stated (both output-enable bits 0, true leg 0).
- R2: Before the pin has been seen high, a low pin has no effect and the enable stays 0. When the pin goes high, the enable is 0 on the second clock edge after the pin change and 1 on the third.
- R3: From reset or power-down until lock, lanes sit at their parked levels. Single-ended outputs are 0. A differential lane with mode bit 0 drives its true leg 1 with its true enable 1 and its complement enable 0. A lane with mode bit 1 has both enables 0.
- R4: When lock is seen, the outputs are unchanged on the next edge. On the second and third edges (WAKE_CYC=2) every differential lane shows true leg 1, true enable 1 and complement enable 0, while single-ended outputs stay 0. On the fourth edge all lanes run together.
- R5: If lock never arrives, the wake level appears on edge LOCK_TMO+1 after the enable rose, and not one edge earlier.
- R6: A pin low that is sampled on only one edge is ignored. A low held across two consecutive samples is accepted as power-down, even if the pin rises again right after.
- R7: After acceptance, a single-ended output keeps following its lane until the lane's first high-to-low transition, sampled from the fifth edge after the pin fell. From then on it stays 0.
- R8: After acceptance, a differential lane keeps running until its true input is first seen rising (its complement leg falling), sampled from the fifth edge. It then parks according to its mode bit: 0 means true leg 1 with complement tri-stated, 1 means both legs tri-stated.
- R9: A lane with no qualifying edge is parked by force on edge 4+PARK_MAX after the pin fell, and not one edge earlier.
- R10: The enable falls only after every lane is parked. It stays 0 while the pin remains low.
- R11: While running, every output equals its lane input as sampled on the same edge (one register stage), each complement leg is the inverse of its true leg, and all output enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pg_pd_pin | input | 1 | Shared pin: power-good first, then active-low power-down request (asynchronous) |
| pll_lock | input | 1 | PLL lock indication |
| drv_mode | input | N_DIFF | Per differential lane: 0 = park true high / complement tri-stated, 1 = both tri-stated |
| se_clk_in | input | N_SE | Single-ended lane waveforms |
| diff_clk_in | input | N_DIFF | True-leg waveforms of the differential lanes |
| pll_osc_en | output | 1 | Enable for the PLL and the crystal oscillator |
| se_clk_out | output | N_SE | Gated single-ended outputs |
| diff_t_out | output | N_DIFF | True-leg output values |
| diff_c_out | output | N_DIFF | Complement-leg output values |
| diff_t_oe | output | N_DIFF | True-leg output enables |
| diff_c_oe | output | N_DIFF | Complement-leg output enables |

## Verification
Two functions can fall in the same cycle. A lane can reach its own qualifying edge on the very cycle the forced park fires. And the last lane can park on the same cycle the pin is released, so shutdown and restart overlap. The bench freezes one single-ended lane high and one differential lane low while the other lanes keep toggling. This makes natural parking and forced parking interleave, and the bench checks the frozen lanes one edge before and exactly at the forced edge. A two-sample pin low that is released at once makes parking, enable removal and re-enable follow back to back. The bench judges this with a per-cycle model of when each lane must freeze, and requires that the enable drops at least once before lock restarts the clocks.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    ST_PG   = 3'd0,
    ST_LOCK = 3'd1,
    ST_WAKE = 3'd2,
    ST_RUN  = 3'd3,
    ST_PARK = 3'd4,
    ST_OFF  = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    LM_HOLD = 2'd0,
    LM_WAKE = 2'd1,
    LM_RUN  = 2'd2,
    LM_PARK = 2'd3
  } lane_mode_t;

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int LOCK_TMO = 40,
  parameter int WAKE_CYC = 2,
  parameter int PARK_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic       pll_lock,
  input  logic       all_parked,
  output lane_mode_t lane_mode,
  output logic       force_park,
  output logic       pll_en
);
  localparam int CMAX0 = (LOCK_TMO > PARK_MAX) ? LOCK_TMO : PARK_MAX;
  localparam int CMAX  = (CMAX0 > WAKE_CYC) ? CMAX0 : WAKE_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  seq_state_t    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pin_d_q;
  logic          pd_req;
  logic          pll_en_n;
  logic          cnt_en;

  // request accepted only after two consecutive low samples
  assign pd_req = ~pin_s & ~pin_d_q;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_PG:   if (pin_s) st_n = ST_LOCK;
      ST_LOCK: begin
        if (pd_req) st_n = ST_OFF;
        else if (pll_lock || (cnt_q == CW'(LOCK_TMO - 1))) st_n = ST_WAKE;
      end
      ST_WAKE: if (cnt_q == CW'(WAKE_CYC - 1)) st_n = ST_RUN;
      ST_RUN:  if (pd_req) st_n = ST_PARK;
      ST_PARK: if (all_parked) st_n = ST_OFF;
      ST_OFF:  if (pin_s) st_n = ST_LOCK;
      default: st_n = ST_PG;
    endcase
  end

  assign cnt_en = (st_q == ST_LOCK) || (st_q == ST_WAKE) || (st_q == ST_PARK);

  always_comb begin
    cnt_n = cnt_q;
    if (st_n != st_q)                       cnt_n = '0;
    else if (cnt_en && (cnt_q != CW'(CMAX))) cnt_n = cnt_q + 1'b1;
  end

  assign pll_en_n = (st_n == ST_LOCK) || (st_n == ST_WAKE) ||
                    (st_n == ST_RUN)  || (st_n == ST_PARK);

  always_comb begin
    unique case (st_q)
      ST_WAKE: lane_mode = LM_WAKE;
      ST_RUN:  lane_mode = LM_RUN;
      ST_PARK: lane_mode = LM_PARK;
      default: lane_mode = LM_HOLD;
    endcase
  end

  assign force_park = (st_q == ST_PARK) && (cnt_q >= CW'(PARK_MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PG;
      cnt_q   <= '0;
      pin_d_q <= 1'b0;
      pll_en  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      pin_d_q <= pin_s;
      pll_en  <= pll_en_n;
    end
  end
endmodule

// File: rtl/pwrdn_se_lane.sv
module pwrdn_se_lane
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lane_mode_t mode,
  input  logic       force_park,
  input  logic       clk_in,
  output logic       clk_out,
  output logic       parked
);
  logic prev_q;
  logic fall;
  logic parked_n;
  logic out_n;

  assign fall = prev_q & ~clk_in;

  always_comb begin
    unique case (mode)
      LM_RUN:  parked_n = 1'b0;
      LM_PARK: parked_n = parked | fall | force_park;
      default: parked_n = 1'b1;
    endcase
    out_n = parked_n ? 1'b0 : clk_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      parked  <= 1'b1;
      clk_out <= 1'b0;
    end else begin
      prev_q  <= clk_in;
      parked  <= parked_n;
      clk_out <= out_n;
    end
  end
endmodule

// File: rtl/pwrdn_diff_lane.sv
module pwrdn_diff_lane
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lane_mode_t mode,
  input  logic       force_park,
  input  logic       tri_mode,
  input  logic       clk_in,
  output logic       t_out,
  output logic       c_out,
  output logic       t_oe,
  output logic       c_oe,
  output logic       parked
);
  logic prev_q;
  logic c_fall;
  logic parked_n;
  logic t_n, c_n, toe_n, coe_n;

  // complement leg falls when the true input rises
  assign c_fall = ~prev_q & clk_in;

  always_comb begin
    unique case (mode)
      LM_RUN:  parked_n = 1'b0;
      LM_PARK: parked_n = parked | c_fall | force_park;
      default: parked_n = 1'b1;
    endcase
    if (mode == LM_WAKE) begin
      t_n = 1'b1; toe_n = 1'b1; c_n = 1'b0; coe_n = 1'b0;
    end else if (parked_n) begin
      t_n = ~tri_mode; toe_n = ~tri_mode; c_n = 1'b0; coe_n = 1'b0;
    end else begin
      t_n = clk_in; toe_n = 1'b1; c_n = ~clk_in; coe_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      parked <= 1'b1;
      t_out  <= 1'b0;
      c_out  <= 1'b0;
      t_oe   <= 1'b0;
      c_oe   <= 1'b0;
    end else begin
      prev_q <= clk_in;
      parked <= parked_n;
      t_out  <= t_n;
      c_out  <= c_n;
      t_oe   <= toe_n;
      c_oe   <= coe_n;
    end
  end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int N_SE     = 3,
  parameter int N_DIFF   = 3,
  parameter int LOCK_TMO = 40,
  parameter int WAKE_CYC = 2,
  parameter int PARK_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_pd_pin,
  input  logic              pll_lock,
  input  logic [N_DIFF-1:0] drv_mode,
  input  logic [N_SE-1:0]   se_clk_in,
  input  logic [N_DIFF-1:0] diff_clk_in,
  output logic              pll_osc_en,
  output logic [N_SE-1:0]   se_clk_out,
  output logic [N_DIFF-1:0] diff_t_out,
  output logic [N_DIFF-1:0] diff_c_out,
  output logic [N_DIFF-1:0] diff_t_oe,
  output logic [N_DIFF-1:0] diff_c_oe
);
  logic              rst_sync_n;
  logic              pin_s;
  lane_mode_t        lane_mode;
  logic              force_park;
  logic [N_SE-1:0]   se_parked;
  logic [N_DIFF-1:0] diff_parked;
  logic              all_parked;

  pwrdn_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pwrdn_sync #(.W(1), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .arst_n(rst_sync_n), .d(pg_pd_pin), .q(pin_s)
  );

  assign all_parked = (&se_parked) & (&diff_parked);

  pwrdn_ctrl #(
    .LOCK_TMO(LOCK_TMO), .WAKE_CYC(WAKE_CYC), .PARK_MAX(PARK_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .pin_s(pin_s), .pll_lock(pll_lock),
    .all_parked(all_parked), .lane_mode(lane_mode),
    .force_park(force_park), .pll_en(pll_osc_en)
  );

  for (genvar gi = 0; gi < N_SE; gi++) begin : g_se
    pwrdn_se_lane u_lane (
      .clk(clk), .rst_n(rst_sync_n), .mode(lane_mode),
      .force_park(force_park), .clk_in(se_clk_in[gi]),
      .clk_out(se_clk_out[gi]), .parked(se_parked[gi])
    );
  end

  for (genvar gd = 0; gd < N_DIFF; gd++) begin : g_diff
    pwrdn_diff_lane u_lane (
      .clk(clk), .rst_n(rst_sync_n), .mode(lane_mode),
      .force_park(force_park), .tri_mode(drv_mode[gd]),
      .clk_in(diff_clk_in[gd]),
      .t_out(diff_t_out[gd]), .c_out(diff_c_out[gd]),
      .t_oe(diff_t_oe[gd]), .c_oe(diff_c_oe[gd]),
      .parked(diff_parked[gd])
    );
  end
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
  parameter int NS = 3,
  parameter int ND = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pin_s,
  input logic          pll_osc_en,
  input logic [NS-1:0] se_clk_out,
  input logic [ND-1:0] diff_t_out,
  input logic [ND-1:0] diff_c_out,
  input logic [ND-1:0] diff_t_oe,
  input logic [ND-1:0] diff_c_oe
);
  // R10: with the enable low, nothing toggles
  p_off_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_osc_en |-> (se_clk_out == '0 && diff_c_oe == '0));

  // R10: enable drops only after lanes were already parked
  p_park_before_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_osc_en) |-> ($past(se_clk_out) == '0 && $past(diff_c_oe) == '0));

  // R11: a driven complement leg is the inverse of its true leg
  p_compl_inverse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((diff_t_out ~^ diff_c_out) & diff_c_oe) == '0);

  // R8: the complement leg is never driven without the true leg
  p_compl_needs_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_c_oe & ~diff_t_oe) == '0);

  // R2: the enable rises only after the synchronized pin was high
  p_enable_after_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_osc_en) |-> $past(pin_s));
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.NS(N_SE), .ND(N_DIFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pll_osc_en(pll_osc_en),
  .se_clk_out(se_clk_out), .diff_t_out(diff_t_out), .diff_c_out(diff_c_out),
  .diff_t_oe(diff_t_oe), .diff_c_oe(diff_c_oe)
);

// File: tb/pwrdn_seq_test.sv
module pwrdn_seq_test;
  localparam int NS = 3, ND = 3, LOCK_TMO = 40, WAKE_CYC = 2, PARK_MAX = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, pin, lock;
  logic [ND-1:0] mode;
  logic [NS-1:0] se_in;
  logic [ND-1:0] d_in;
  logic          pll_osc_en;
  logic [NS-1:0] se_clk_out;
  logic [ND-1:0] diff_t_out, diff_c_out, diff_t_oe, diff_c_oe;

  pwrdn_seq #(.N_SE(NS), .N_DIFF(ND), .LOCK_TMO(LOCK_TMO),
              .WAKE_CYC(WAKE_CYC), .PARK_MAX(PARK_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .pg_pd_pin(pin), .pll_lock(lock),
    .drv_mode(mode), .se_clk_in(se_in), .diff_clk_in(d_in),
    .pll_osc_en(pll_osc_en), .se_clk_out(se_clk_out),
    .diff_t_out(diff_t_out), .diff_c_out(diff_c_out),
    .diff_t_oe(diff_t_oe), .diff_c_oe(diff_c_oe)
  );

  int total = 0, bad = 0;
  logic [NS-1:0] se_cur, se_prv, se_fell;
  logic [ND-1:0] d_cur, d_prv, d_rose;
  int se_hp[NS], se_ct[NS], d_hp[ND], d_ct[ND];
  bit se_frz[NS], d_frz[ND];
  bit chk_run, chk_park, saw_off;
  int pk;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit park_ok();
    return se_clk_out == '0 && diff_c_oe == '0 && diff_t_oe == ~mode &&
           ((diff_t_out & ~mode) == ~mode);
  endfunction

  function automatic bit wake_ok();
    return se_clk_out == '0 && diff_t_out == '1 && diff_t_oe == '1 && diff_c_oe == '0;
  endfunction

  function automatic logic [31:0] pack_diff();
    return {diff_t_out, diff_c_out, diff_t_oe, diff_c_oe, se_clk_out};
  endfunction

  task automatic tick();
    logic [NS-1:0] exp_se;
    logic [ND-1:0] exp_t, exp_toe, exp_coe;
    @(negedge clk);
    if (!pll_osc_en) saw_off = 1'b1;
    if (chk_run) begin
      check(se_clk_out == se_cur, "R11 se follow", se_clk_out, se_cur);
      check(diff_t_out == d_cur && diff_c_out == ~d_cur && diff_t_oe == '1 && diff_c_oe == '1,
            "R11 diff follow", pack_diff(), {d_cur, ~d_cur, {ND{1'b1}}, {ND{1'b1}}, se_cur});
    end
    if (chk_park) begin
      pk++;
      if (pk >= 5) begin
        for (int i = 0; i < NS; i++) if (se_prv[i] && !se_cur[i]) se_fell[i] = 1'b1;
        for (int i = 0; i < ND; i++) if (!d_prv[i] && d_cur[i]) d_rose[i] = 1'b1;
      end
      if (pk >= 4 + PARK_MAX) begin se_fell = '1; d_rose = '1; end
      exp_se  = se_cur & ~se_fell;
      exp_t   = (d_cur & ~d_rose) | (~mode & d_rose);
      exp_toe = ~d_rose | ~mode;
      exp_coe = ~d_rose;
      check(se_clk_out == exp_se, "R7 se park", se_clk_out, exp_se);
      check(diff_t_out == exp_t && diff_t_oe == exp_toe && diff_c_oe == exp_coe,
            "R8 diff park", {diff_t_out, diff_t_oe, diff_c_oe}, {exp_t, exp_toe, exp_coe});
    end
    se_prv = se_cur;
    d_prv  = d_cur;
    for (int i = 0; i < NS; i++) if (!se_frz[i]) begin
      se_ct[i]++;
      if (se_ct[i] >= se_hp[i]) begin se_ct[i] = 0; se_cur[i] = ~se_cur[i]; end
    end
    for (int i = 0; i < ND; i++) if (!d_frz[i]) begin
      d_ct[i]++;
      if (d_ct[i] >= d_hp[i]) begin d_ct[i] = 0; d_cur[i] = ~d_cur[i]; end
    end
    se_in = se_cur;
    d_in  = d_cur;
  endtask

  task automatic new_lanes();
    for (int i = 0; i < NS; i++) begin se_hp[i] = $urandom_range(1, 3); se_ct[i] = 0; end
    for (int i = 0; i < ND; i++) begin d_hp[i] = $urandom_range(1, 3); d_ct[i] = 0; end
    mode = ND'($urandom) | ND'(1);
  endtask

  task automatic lock_and_wake(int w);
    chk_park = 1'b0;
    for (int i = 0; i < w; i++) begin
      tick(); check(park_ok(), "R3 held before lock", pack_diff(), {{ND{1'b0}}, {ND{1'b0}}, ~mode, {ND{1'b0}}, {NS{1'b0}}});
    end
    lock = 1'b1;
    tick(); check(park_ok(), "R4 no change one edge after lock", pack_diff(), 0);
    tick(); check(wake_ok(), "R4 wake level edge 2", pack_diff(), 0);
    tick(); check(wake_ok(), "R4 wake level edge 3", pack_diff(), 0);
    chk_run = 1'b1;
    tick();
  endtask

  task automatic power_up(int lock_wait, bit via_timeout);
    chk_park = 1'b0;
    pin = 1'b1;
    tick(); tick(); check(pll_osc_en == 1'b0, "R2 enable not yet", pll_osc_en, 0);
    tick();         check(pll_osc_en == 1'b1, "R2 enable on third edge", pll_osc_en, 1);
    if (via_timeout) begin
      for (int i = 0; i < LOCK_TMO; i++) begin
        tick(); check(park_ok(), "R5 no wake before timeout", pack_diff(), 0);
      end
      tick(); check(wake_ok(), "R5 wake at timeout", pack_diff(), 0);
      tick(); check(wake_ok(), "R4 wake second edge", pack_diff(), 0);
      chk_run = 1'b1;
      tick();
    end else begin
      lock_and_wake(lock_wait);
    end
  endtask

  task automatic power_down(bit forced);
    lock = 1'b0;
    pin = 1'b0;
    chk_run = 1'b0; chk_park = 1'b1; pk = 0; se_fell = '0; d_rose = '0;
    for (int i = 0; i < PARK_MAX + 10; i++) begin
      tick();
      if (forced && pk == 3 + PARK_MAX)
        check(se_clk_out[0] == 1'b1 && diff_c_oe[0] == 1'b1, "R9 not before limit",
              {se_clk_out[0], diff_c_oe[0]}, 2'b11);
      if (forced && pk == 4 + PARK_MAX)
        check(se_clk_out[0] == 1'b0 && diff_c_oe[0] == 1'b0, "R9 forced at limit",
              {se_clk_out[0], diff_c_oe[0]}, 2'b00);
    end
    check(pll_osc_en == 1'b0, "R10 enable off after park", pll_osc_en, 0);
    for (int i = 0; i < 10; i++) tick();
    check(pll_osc_en == 1'b0, "R10 enable stays off", pll_osc_en, 0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; pin = 1'b0; lock = 1'b0;
    chk_run = 0; chk_park = 0; saw_off = 0; pk = 0;
    se_cur = '0; d_cur = '0; se_prv = '0; d_prv = '0; se_fell = '0; d_rose = '0;
    for (int i = 0; i < NS; i++) se_frz[i] = 0;
    for (int i = 0; i < ND; i++) d_frz[i] = 0;
    new_lanes();
    se_in = se_cur; d_in = d_cur;
    tick(); tick(); tick();
    check(pll_osc_en == 0 && se_clk_out == '0 && diff_t_oe == '0 && diff_c_oe == '0 && diff_t_out == '0,
          "R1 reset state", pack_diff(), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) tick();
    check(pll_osc_en == 1'b0, "R2 low pin ignored before power-good", pll_osc_en, 0);
    check(park_ok(), "R3 parked before power-good", pack_diff(), 0);
    power_up(0, 1'b1);
    for (int i = 0; i < 30; i++) tick();

    // single-sample low: ignored
    pin = 1'b0; tick(); pin = 1'b1;
    for (int i = 0; i < 12; i++) tick();
    check(pll_osc_en == 1'b1, "R6 one-sample low ignored", pll_osc_en, 1);

    for (int r = 0; r < 6; r++) begin
      new_lanes();
      for (int i = 0; i < $urandom_range(20, 50); i++) tick();
      if (r % 3 == 1) begin
        se_frz[0] = 1; se_cur[0] = 1'b1; d_frz[0] = 1; d_cur[0] = 1'b0;
        se_in = se_cur; d_in = d_cur;
        for (int i = 0; i < 4; i++) tick();
        power_down(1'b1);
        se_frz[0] = 0; d_frz[0] = 0;
      end else begin
        power_down(1'b0);
      end
      power_up($urandom_range(2, 15), r % 3 == 2);
    end

    // two-sample low then immediate release: accepted
    for (int i = 0; i < 20; i++) tick();
    lock = 1'b0; saw_off = 1'b0;
    pin = 1'b0; chk_run = 1'b0; chk_park = 1'b1; pk = 0; se_fell = '0; d_rose = '0;
    tick(); tick(); pin = 1'b1;
    for (int i = 0; i < 22; i++) tick();
    check(saw_off == 1'b1, "R6 two-sample low accepted", saw_off, 1);
    check(pll_osc_en == 1'b1, "R2 enable back after release", pll_osc_en, 1);
    lock_and_wake(2);
    for (int i = 0; i < 20; i++) tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule